// File: doc/BRIEF.md
# Prescaled PWM Channel with Boundary-Synchronised Settings

This block produces one pulse-width-modulated output. A power-of-two prescaler turns the input clock into a slower tick. A 16-bit period counter advances on that tick, counting from zero up to a programmed limit and then wrapping. Within each period the counter marks an active window. The pin is driven to one level inside that window and to another level outside it. Each level is chosen by its own two-bit drive code, so normal and inverted polarity are only two of the possible pairs.

Software places a full setting on the staging inputs and pulses a commit strobe. The setting is the period limit, the window entry tick, the window exit (duty) tick, the two drive codes and the divider select. The block latches it into a pending holder. The working copy takes the pending values only when the counter wraps, so a period that is already running is never cut short or distorted. While the channel is disabled, the pin is held low, the counter and prescaler sit at zero, and any pending setting is taken at once. The next enable therefore starts a clean period with that setting.

Top module: `pwm_shadow_chan`

## Requirements
- R1: The 3-bit divider select maps codes 0,1,2,3,4,5,6,7 to a tick every 2^0, 2^1, 2^2, 2^3, 2^4, 2^6, 2^8, 2^10 clock cycles. One PWM period therefore lasts (period limit + 1) << shift clock cycles.
- R2: The counter steps only on a prescaler tick. It never exceeds the working period limit, and it returns to 0 on the tick after it reaches that limit.
- R3: With a nonzero exit tick below the period limit, the output is in the active state for counter values v with entry <= v < exit. An entry tick of 0 makes it active from the start of the period. An entry tick at or after the exit tick gives no active ticks.
- R4: An exit tick of 0 means the output is never active. An exit tick at or above the period limit keeps the output active from the entry tick through the last tick of the period (the tick equal to the limit).
- R5: Drive code 3 drives the pin high, and codes 2, 1 and 0 drive it low. The active-window code applies inside the window and the idle code applies everywhere else. Normal polarity is the pair (active 3, idle 2) and inverted polarity is (active 2, idle 3).
- R6: A commit pulse stages all settings together. A running channel adopts them only on the clock edge where the counter wraps. The rest of the current period keeps the old level pattern, and the first displayed tick of the next period uses the new one.
- R7: With enable low, the pin is low from the next clock edge, and the counter and prescaler are held at zero. Pending settings are adopted immediately. On the first clock edge with enable high, the pin takes the level for counter value 0.
- R8: The pin is registered and shows the level of a counter value one clock after that value is held. After reset the working settings are all zero, which drives the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable |
| commit | input | 1 | One-cycle strobe that latches the staging inputs as pending |
| cfg_period | input | 16 | Staged period limit (last counter value of a period) |
| cfg_on_tick | input | 16 | Staged tick at which the active window opens |
| cfg_off_tick | input | 16 | Staged duty tick at which the active window closes |
| cfg_act_drv | input | 2 | Staged drive code for the active window |
| cfg_idle_drv | input | 2 | Staged drive code outside the active window |
| cfg_div_sel | input | 3 | Staged prescaler select |
| pwm_out | output | 1 | PWM pin level |

## Verification
On every cycle the assertions check the following. The counter stays within the working limit, moves only on a tick and clears after a wrap. The prescaler and pin stay idle while the channel is disabled. The working settings change only at a wrap or while the channel is disabled, and when they change they take the pending values. Only the bench scenarios can show the time-domain results: the duty fraction and period length for each divider code, window edge cases and drive codes, the exact cycle at which a committed polarity change appears on the pin, and the restart of a clean period after re-enable.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    localparam int CNT_W   = 16;
    localparam int SEL_W   = 3;
    localparam int DRV_W   = 2;
    localparam int PRE_W   = 10;
    localparam logic [DRV_W-1:0] DRV_HIGH = DRV_W'(3);

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] on_tick;
        logic [CNT_W-1:0] off_tick;
        logic [DRV_W-1:0] act_drv;
        logic [DRV_W-1:0] idle_drv;
        logic [SEL_W-1:0] div_sel;
    } chan_cfg_t;

    // Shift is linear for codes 0..3 and then climbs in steps of two.
    function automatic int unsigned div_shift(input logic [SEL_W-1:0] sel);
        int unsigned s;
        s = int'(sel);
        return (s < 4) ? s : (2 * s - 4);
    endfunction

endpackage

// File: rtl/pwm_cfg_stage.sv
module pwm_cfg_stage
    import pwm_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      commit,
    input  chan_cfg_t cfg_in,
    input  logic      load,
    output chan_cfg_t shadow
);

    typedef struct packed {
        chan_cfg_t pend;
        logic      pend_vld;
        chan_cfg_t work;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load && st_q.pend_vld) begin
            st_d.work     = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
        if (commit) begin
            st_d.pend     = cfg_in;
            st_d.pend_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow = st_q.work;

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.work));

    assert_shadow_adopt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st_q.pend_vld) |=> (st_q.work == $past(st_q.pend)));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_chan_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t       pr_d, pr_q;
    logic [W:0] limit;

    always_comb begin
        limit = ((W+1)'(1) << div_shift(div_sel)) - (W+1)'(1);
        tick  = en && ({1'b0, pr_q.cnt} == limit);
        pr_d  = pr_q;
        if (!en || tick) pr_d.cnt = '0;
        else             pr_d.cnt = pr_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assert_pre_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pr_q.cnt == '0));

    assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, pr_q.cnt} <= limit);

endmodule

// File: rtl/pwm_window.sv
module pwm_window
    import pwm_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      tick,
    input  chan_cfg_t cfg,
    output logic      wrap,
    output logic      pin
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
    } win_t;

    win_t win_d, win_q;
    logic active;
    logic level;

    always_comb begin
        wrap   = tick && (win_q.cnt == cfg.period);
        active = (cfg.off_tick != '0) && (win_q.cnt >= cfg.on_tick) &&
                 ((win_q.cnt < cfg.off_tick) || (cfg.off_tick >= cfg.period));
        level  = active ? (cfg.act_drv == DRV_HIGH) : (cfg.idle_drv == DRV_HIGH);

        win_d     = win_q;
        win_d.out = en && level;
        if (!en)       win_d.cnt = '0;
        else if (wrap) win_d.cnt = '0;
        else if (tick) win_d.cnt = win_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign pin = win_q.out;

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.cnt <= cfg.period);

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(win_q.cnt));

    assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (win_q.cnt == '0));

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             commit,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_on_tick,
    input  logic [CNT_W-1:0] cfg_off_tick,
    input  logic [DRV_W-1:0] cfg_act_drv,
    input  logic [DRV_W-1:0] cfg_idle_drv,
    input  logic [SEL_W-1:0] cfg_div_sel,
    output logic             pwm_out
);

    chan_cfg_t staged;
    chan_cfg_t working;
    logic      tick;
    logic      wrap;
    logic      load;

    always_comb begin
        staged.period   = cfg_period;
        staged.on_tick  = cfg_on_tick;
        staged.off_tick = cfg_off_tick;
        staged.act_drv  = cfg_act_drv;
        staged.idle_drv = cfg_idle_drv;
        staged.div_sel  = cfg_div_sel;
        load            = wrap || !en;
    end

    pwm_cfg_stage i_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .cfg_in (staged),
        .load   (load),
        .shadow (working)
    );

    pwm_prescaler #(.W(PRE_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .div_sel (working.div_sel),
        .tick    (tick)
    );

    pwm_window i_win (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick),
        .cfg   (working),
        .wrap  (wrap),
        .pin   (pwm_out)
    );

    assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);

endmodule

// File: tb/test_pwm_shadow_chan.sv
module test_pwm_shadow_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        commit = 1'b0;
    logic [15:0] cfg_period = '0, cfg_on_tick = '0, cfg_off_tick = '0;
    logic [1:0]  cfg_act_drv = '0, cfg_idle_drv = '0;
    logic [2:0]  cfg_div_sel = '0;
    logic        pwm_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwm_shadow_chan i_pwm_shadow_chan (
        .clk(clk), .rst_n(rst_n), .en(en), .commit(commit),
        .cfg_period(cfg_period), .cfg_on_tick(cfg_on_tick),
        .cfg_off_tick(cfg_off_tick), .cfg_act_drv(cfg_act_drv),
        .cfg_idle_drv(cfg_idle_drv), .cfg_div_sel(cfg_div_sel),
        .pwm_out(pwm_out)
    );

    typedef struct packed {
        int per; int on; int off; int act; int idle; int dsel;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{9, 0, 5, 3, 2, 0},
        '{9, 0, 5, 2, 3, 0},
        '{7, 2, 6, 3, 2, 1},
        '{4, 0, 0, 3, 2, 2},
        '{4, 1, 9, 3, 2, 3},
        '{3, 0, 2, 3, 2, 4},
        '{3, 1, 3, 3, 2, 5},
        '{2, 0, 1, 3, 2, 6},
        '{1, 0, 1, 3, 2, 7},
        '{5, 0, 3, 1, 2, 0},
        '{5, 0, 3, 0, 3, 0},
        '{6, 4, 2, 3, 2, 0}
    };

    function automatic int shift_of(int code);
        case (code)
            0: return 0;  1: return 1;  2: return 2;  3: return 3;
            4: return 4;  5: return 6;  6: return 8;  default: return 10;
        endcase
    endfunction

    function automatic int active_ticks(vec_t v);
        if (v.off == 0)        return 0;
        if (v.off >= v.per)    return (v.on <= v.per) ? v.per - v.on + 1 : 0;
        return (v.on < v.off) ? v.off - v.on : 0;
    endfunction

    function automatic int high_cycles(vec_t v);
        int a;
        int h;
        a = active_ticks(v);
        h = ((v.act == 3) ? a : 0) + ((v.idle == 3) ? (v.per + 1 - a) : 0);
        return h << shift_of(v.dsel);
    endfunction

    function automatic int period_cycles(vec_t v);
        return (v.per + 1) << shift_of(v.dsel);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        cfg_period   = 16'(v.per);
        cfg_on_tick  = 16'(v.on);
        cfg_off_tick = 16'(v.off);
        cfg_act_drv  = 2'(v.act);
        cfg_idle_drv = 2'(v.idle);
        cfg_div_sel  = 3'(v.dsel);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    // Returns at the negedge where pwm_out has just risen; found=0 on timeout.
    task automatic wait_rise(input int limit, output bit found);
        bit prev;
        found = 1'b0;
        prev  = pwm_out;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (!prev && pwm_out) begin
                found = 1'b1;
                break;
            end
            prev = pwm_out;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        int prev_pc;
        bit found;
        int hi;
        int gap;
        vec_t norm;
        vec_t inv;

        // R8: reset state and zeroed working settings drive low.
        repeat (3) @(negedge clk);
        chk("R8 out during reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            hi += int'(pwm_out);
        end
        chk("R8 zero settings keep pin low", hi, 0);

        // Vector table: duty fraction and period per configuration.
        prev_pc = 1;
        for (int r = 0; r < NV; r++) begin
            int pc;
            pc = period_cycles(VECS[r]);
            apply(VECS[r]);
            repeat (2 * prev_pc + 2 * pc + 4) @(negedge clk);
            hi = 0;
            for (int c = 0; c < 2 * pc; c++) begin
                @(negedge clk);
                hi += int'(pwm_out);
            end
            chk($sformatf("R1 R3 R4 R5 row %0d high cycles", r), hi, 2 * high_cycles(VECS[r]));
            if (high_cycles(VECS[r]) > 0 && high_cycles(VECS[r]) < pc) begin
                wait_rise(2 * pc + 4, found);
                gap = 0;
                if (found) begin
                    bit f2;
                    for (int c = 0; c < 2 * pc + 4; c++) begin
                        bit p;
                        p = pwm_out;
                        @(negedge clk);
                        gap++;
                        if (!p && pwm_out) begin
                            f2 = 1'b1;
                            break;
                        end
                    end
                end
                chk($sformatf("R1 R2 row %0d period length", r), gap, pc);
            end
            prev_pc = pc;
        end

        // R6: polarity change committed mid-period waits for the wrap.
        norm = '{9, 0, 5, 3, 2, 0};
        inv  = '{9, 0, 5, 2, 3, 0};
        apply(norm);
        repeat (2 * 1024 + 40) @(negedge clk);
        wait_rise(40, found);
        chk("R6 found period start", int'(found), 1);
        @(negedge clk);                    // shows tick 1
        @(negedge clk);                    // shows tick 2
        cfg_act_drv  = 2'd2;
        cfg_idle_drv = 2'd3;
        commit = 1'b1;
        for (int k = 3; k <= 9; k++) begin
            @(negedge clk);
            commit = 1'b0;
            chk($sformatf("R6 old pattern tick %0d", k), int'(pwm_out), (k < 5) ? 1 : 0);
        end
        for (int k = 0; k <= 9; k++) begin
            @(negedge clk);
            chk($sformatf("R6 new pattern tick %0d", k), int'(pwm_out), (k < 5) ? 0 : 1);
        end

        // R7: disable forces low; pending settings adopted while off; clean restart.
        @(negedge clk);
        en = 1'b0;
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            hi += int'(pwm_out);
        end
        chk("R7 disabled pin low", hi, 0);
        apply(norm);
        repeat (3) @(negedge clk);
        en = 1'b1;
        for (int k = 0; k <= 9; k++) begin
            @(negedge clk);
            chk($sformatf("R7 R8 restart tick %0d", k), int'(pwm_out), (k < 5) ? 1 : 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule